// File: doc/BRIEF.md
# CORDIC Universal Modulator

This block turns a stream of message samples into a quadrature carrier pair. A 16-bit phase accumulator advances by a frequency increment on every accepted sample. A phase offset is added to the accumulator value, and the sum, together with an input vector (x, y), enters a rotation-mode CORDIC of eight shift-and-add iterations. The CORDIC rotates the vector by the summed phase and delivers the two rotated components as the in-phase (cosine) and quadrature (sine) carrier samples.

The same datapath acts as an amplitude, frequency or phase modulator. The caller chooses which input carries the message and holds the others constant. The message on the vector inputs gives AM. The message on the increment, with y and the offset at zero, gives FM. The message on the offset, with y at zero and the increment fixed, gives PM. With x at full scale, y at zero, no offset and a fixed increment, the outputs are the plain carrier.

Before the iterations, the top two phase bits select a quarter-turn pre-rotation, so every phase code converges. The CORDIC gain is cancelled up front by scaling the vector with the inverse gain constant. Results that exceed the output range are clamped. The datapath is fully pipelined, with one register per iteration plus an entry register.

Top module: `cordic_univ_mod`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, out_valid is low. Reset clears the phase accumulator, so the first sample accepted after reset uses a phase equal to its own phase_ofs.
- R2: A sample accepted (in_valid high) at clock edge t produces out_valid high in the cycle that follows edge t+8. Each accepted sample gives exactly one output, in order. out_valid is low in every other cycle.
- R3: The accumulator adds freq_inc only on accepted samples, modulo 2^16, with no saturation. Accepted sample k uses the phase (phase_ofs_k + sum of freq_inc_j over earlier accepted samples j) mod 2^16. A sample's own increment first affects the next sample, and idle cycles leave the accumulator unchanged.
- R4: The phase is an unsigned 16-bit code with one LSB equal to 2*pi/65536 rad. Bits 15:14 give the quadrant.
- R5: x_in, y_in, cos_out and sin_out are signed Q1.15. For phase theta, cos_out approximates x*cos(theta) - y*sin(theta) and sin_out approximates x*sin(theta) + y*cos(theta). The error is within |v|/96 + 24 LSB, where |v| = sqrt(x^2 + y^2) in LSB.
- R6: The R5 accuracy holds for every phase code over the full turn, including the exact quadrant boundaries 0, 16384, 32768 and 49152.
- R7: A result whose ideal value lies above 32767 is clamped to exactly 32767. A result whose ideal value lies below -32768 is clamped to exactly -32768.
- R8: The R5 accuracy holds in each modulation use when a new message value arrives every cycle: AM (x and y vary), FM (freq_inc varies) and PM (phase_ofs varies).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept the inputs in this cycle |
| freq_inc | input | 16 | Phase increment per accepted sample |
| phase_ofs | input | 16 | Phase added after the accumulator |
| x_in | input | 16 | Input vector x component, signed Q1.15 |
| y_in | input | 16 | Input vector y component, signed Q1.15 |
| out_valid | output | 1 | Carrier samples valid |
| cos_out | output | 16 | In-phase carrier sample, signed Q1.15 |
| sin_out | output | 16 | Quadrature carrier sample, signed Q1.15 |

## Verification
Two functions can act in the same cycle. The accumulator can wrap past 2^16 while the added offset moves the summed phase across a quadrant boundary, so the wrap and the pre-rotation select both act on one sample. The bench provokes this with a large increment near 2^16, a rotating offset and irregular idle gaps between samples. It judges each output against a real-valued rotation of (x, y) by the phase that an arithmetic modulo-2^16 model of the accumulator predicts. Saturation and pre-rotation also coincide when a full-scale vector is swept around the circle. There, an exact clamped value is required wherever the ideal result lies beyond the range by more than the tolerance.

// File: rtl/cordic_univ_mod.sv
module cordic_univ_mod #(
  parameter int W     = 16,
  parameter int AW    = 16,
  parameter int GUARD = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [AW-1:0]       freq_inc,
  input  logic [AW-1:0]       phase_ofs,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  output logic                out_valid,
  output logic signed [W-1:0] cos_out,
  output logic signed [W-1:0] sin_out
);
  localparam int N  = 8;
  localparam int IW = W + GUARD;
  localparam int PW = W + 17;
  // inverse gain of eight iterations, Q0.15
  localparam logic signed [16:0] KINV = 17'sd19899;
  localparam logic [AW-1:0] QTR = AW'(1) << (AW-2);
  localparam logic signed [IW-1:0] HI = IW'((1 << (W-1)) - 1);
  localparam logic signed [IW-1:0] LO = ~HI;

  function automatic logic signed [AW-1:0] atan_step(input int i);
    int v;
    case (i)
      0: v = 8192;
      1: v = 4836;
      2: v = 2555;
      3: v = 1297;
      4: v = 651;
      5: v = 326;
      6: v = 163;
      default: v = 81;
    endcase
    return AW'((v * (1 << AW)) / 65536);
  endfunction

  function automatic logic signed [W-1:0] sat(input logic signed [IW-1:0] v);
    if (v > HI)      return {1'b0, {(W-1){1'b1}}};
    else if (v < LO) return {1'b1, {(W-1){1'b0}}};
    else             return v[W-1:0];
  endfunction

  logic [AW-1:0] phase_acc;
  logic [AW-1:0] phase_sum;
  logic signed [PW-1:0] px, py;
  logic signed [IW-1:0] sx, sy, a0, b0;
  logic signed [AW-1:0] z0;

  logic signed [IW-1:0] a_q [0:N];
  logic signed [IW-1:0] b_q [0:N];
  logic signed [AW-1:0] z_q [0:N];
  logic [N:0] v_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        phase_acc <= '0;
    else if (in_valid) phase_acc <= phase_acc + freq_inc;
  end

  assign phase_sum = phase_acc + phase_ofs;
  assign px = PW'(x_in) * PW'(KINV);
  assign py = PW'(y_in) * PW'(KINV);
  assign sx = IW'(px >>> 15);
  assign sy = IW'(py >>> 15);

  always_comb begin
    case (phase_sum[AW-1:AW-2])
      2'b01: begin a0 = -sy; b0 = sx;  z0 = $signed(phase_sum - QTR); end
      2'b10: begin a0 = sy;  b0 = -sx; z0 = $signed(phase_sum + QTR); end
      default: begin a0 = sx; b0 = sy; z0 = $signed(phase_sum); end
    endcase
  end

  always_ff @(posedge clk) begin
    a_q[0] <= a0;
    b_q[0] <= b0;
    z_q[0] <= z0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= {v_q[N-1:0], in_valid};
  end

  for (genvar i = 0; i < N; i++) begin : g_iter
    always_ff @(posedge clk) begin
      if (z_q[i][AW-1]) begin
        a_q[i+1] <= a_q[i] + (b_q[i] >>> i);
        b_q[i+1] <= b_q[i] - (a_q[i] >>> i);
        z_q[i+1] <= z_q[i] + atan_step(i);
      end else begin
        a_q[i+1] <= a_q[i] - (b_q[i] >>> i);
        b_q[i+1] <= b_q[i] + (a_q[i] >>> i);
        z_q[i+1] <= z_q[i] - atan_step(i);
      end
    end
  end

  assign out_valid = v_q[N];
  assign cos_out   = sat(a_q[N]);
  assign sin_out   = sat(b_q[N]);
endmodule

// File: rtl/cum_checker.sv
module cum_checker #(
  parameter int AW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [AW-1:0]        acc,
  input logic                 v0,
  input logic signed [AW-1:0] z0,
  input logic signed [AW-1:0] zn
);
  localparam logic signed [AW-1:0] QP = AW'(1) <<< (AW-2);
  localparam logic signed [AW-1:0] QN = -QP;
  localparam logic signed [AW-1:0] RB = AW'(128);
  localparam logic signed [AW-1:0] RBN = -RB;

  logic [8:0] sh;
  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[7:0], in_valid};
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == sh[8]);

  assert_acc_holds_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc));

  assert_prerot_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    v0 |-> (z0 >= QN && z0 <= QP));

  assert_residual_small_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (zn > RBN && zn < RB));
endmodule

bind cordic_univ_mod cum_checker #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .acc(phase_acc), .v0(v_q[0]), .z0(z_q[0]), .zn(z_q[N])
);

// File: tb/tb_cordic_univ_mod.sv
module tb_cordic_univ_mod;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, out_valid;
  logic [15:0] freq_inc, phase_ofs;
  logic signed [15:0] x_in, y_in, cos_out, sin_out;

  cordic_univ_mod dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .freq_inc(freq_inc),
    .phase_ofs(phase_ofs), .x_in(x_in), .y_in(y_in), .out_valid(out_valid),
    .cos_out(cos_out), .sin_out(sin_out)
  );

  localparam real PI = 3.14159265358979;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0, m_acc = 0;
  bit done = 0;
  real q_ec[$], q_es[$], q_tol[$];
  int  q_cyc[$];
  string q_tag[$];

  task automatic judge(string tag, string what, real ideal, real tol, int act);
    int exp_i;
    bit ok;
    checks++;
    exp_i = int'(ideal);
    if (ideal >= 32767.0 + tol) begin
      exp_i = 32767; ok = (act == 32767);
    end else if (ideal <= -32768.0 - tol) begin
      exp_i = -32768; ok = (act == -32768);
    end else begin
      real c = ideal > 32767.0 ? 32767.0 : (ideal < -32768.0 ? -32768.0 : ideal);
      real d = act - c;
      exp_i = int'(c);
      ok = (d <= tol) && (d >= -tol);
    end
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (tol %0d)", tag, what, act, exp_i, int'(tol));
    end
  endtask

  task automatic send(int x, int y, int inc, int ofs, string tag);
    int ph;
    real th;
    @(negedge clk);
    in_valid = 1'b1;
    x_in = 16'(x); y_in = 16'(y);
    freq_inc = 16'(inc); phase_ofs = 16'(ofs);
    ph = (m_acc + ofs) & 16'hFFFF;
    th = 2.0 * PI * ph / 65536.0;
    q_ec.push_back(x * $cos(th) - y * $sin(th));
    q_es.push_back(x * $sin(th) + y * $cos(th));
    q_tol.push_back($sqrt(real'(x) * x + real'(y) * y) / 96.0 + 24.0);
    q_cyc.push_back(cyc);
    q_tag.push_back(tag);
    m_acc = (m_acc + inc) & 16'hFFFF;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1 && !done) begin
      if (q_cyc.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected out_valid: actual=1 expected=0");
      end else begin
        int c0;
        real ec, es, tl;
        string tg;
        c0 = q_cyc.pop_front(); ec = q_ec.pop_front(); es = q_es.pop_front();
        tl = q_tol.pop_front(); tg = q_tag.pop_front();
        checks++;
        if (cyc != c0 + 9) begin
          errors++;
          $display("FAIL R2 latency: actual=%0d expected=%0d", cyc - c0, 9);
        end
        judge(tg, "cos", ec, tl, int'(cos_out));
        judge(tg, "sin", es, tl, int'(sin_out));
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b1;
    x_in = 16'sd1000; y_in = 16'sd1000; freq_inc = 16'd5000; phase_ofs = 16'd77;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++; $display("FAIL R1 out_valid in reset: actual=%b expected=0", out_valid);
      end
    end
    @(negedge clk);
    rst_n = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R1 out_valid after reset: actual=%b expected=0", out_valid);
    end
    m_acc = 0;
    // R1: first sample after reset takes phase from its own offset only
    send(30000, 0, 9000, 12000, "R1");
    // R4 R6: full-circle sweep of the phase code, boundaries included
    for (int k = 0; k < 512; k++) send(30000, 0, 0, k * 128 - m_acc, "R6");
    for (int k = 0; k < 4; k++) send(20000, 9000, 0, k * 16384 - m_acc, "R4");
    // R5: unmodulated carrier
    for (int k = 0; k < 300; k++) send(26000, 0, 1000, 0, "R5");
    idle(3);
    // R8: amplitude, frequency and phase modulation
    for (int k = 0; k < 300; k++)
      send((k * 911) % 40000 - 20000, (k * 577) % 30000 - 15000, 700, 0, "R8 AM");
    for (int k = 0; k < 300; k++) send(25000, 0, 500 + (k * 37) % 4000, 0, "R8 FM");
    for (int k = 0; k < 300; k++) send(25000, 0, 1200, (k * 2731) % 65536, "R8 PM");
    // R3: wrap with large increment, rotating offset, idle gaps
    for (int k = 0; k < 200; k++) begin
      send(28000, -5000, 16'hF123, (k * 4099) % 65536, "R3");
      idle((k * 7) % 4);
    end
    // R7: full-scale vector around the circle, clamping where needed
    for (int k = 0; k < 64; k++) send(32767, 32767, 0, k * 1024 - m_acc, "R7");
    send(32767, 32767, 0, 8192 - m_acc, "R7");
    send(32767, 32767, 0, 40960 - m_acc, "R7");
    send(-32768, 32767, 0, 24576 - m_acc, "R7");
    idle(20);
    checks++;
    if (q_cyc.size() != 0) begin
      errors++; $display("FAIL R2 missing outputs: actual=%0d expected=0 pending", q_cyc.size());
    end
    finish_run();
  end
endmodule